// File: doc/BRIEF.md
# Watch-Rate Clock Timer

This block divides a 32.768 kHz oscillator rate into eight binary timing taps, from 128 Hz down to 1 Hz. It runs on the system clock. A single-cycle oscillator enable tick advances a 15-bit count. The eight most significant count bits are the tap levels, and software reads them as two 4-bit data registers. Software can start or stop the count, and it can clear the count through a self-clearing control bit.

Three of the taps raise periodic events on their falling edges: 32 Hz, 8 Hz and 2 Hz. Each event sets a sticky flag whether or not its enable mask is set. A flag stays set until software reads the flag register, and that read clears all flags. The block drives one interrupt request. The request is high while any flag is set and its mask is also set.

Register map (3-bit address, 4-bit data):

| Address | Access | Bit 3 | Bit 2 | Bit 1 | Bit 0 |
|---|---|---|---|---|---|
| 0 | read only | 16 Hz | 32 Hz | 64 Hz | 128 Hz |
| 1 | read only | 1 Hz | 2 Hz | 4 Hz | 8 Hz |
| 2 | read/write | 0 | 0 | clear (write 1, reads 0) | run |
| 3 | read/write | 0 | 2 Hz enable | 8 Hz enable | 32 Hz enable |
| 4 | read, clear on read | 0 | 2 Hz flag | 8 Hz flag | 32 Hz flag |

Top module: `tick_timer`

## Requirements
- R1: After system reset, the run bit, the count, the masks, the flags and `irq` are all 0. Registers 0 to 4 read as 0.
- R2: While run is 1, each cycle with `osc_tick` high adds one to the count. Address 0 reads count bits 10..7 and address 1 reads count bits 14..11, with bit 0 of each register being the lowest of its four count bits.
- R3: While run is 0, the count holds and no flag is set, whatever `osc_tick` does. A write to address 2 sets run from wdata bit 0.
- R4: A write to address 2 with wdata bit 1 set clears the count to 0 at that clock edge. This takes priority over a tick in the same cycle. Bit 1 of address 2 always reads 0.
- R5: Flag bits 0, 1 and 2 at address 4 are set when count bit 9 (32 Hz), bit 11 (8 Hz) or bit 13 (2 Hz) falls from 1 to 0 on an increment. They are set whatever the mask says.
- R6: A read of address 4 returns the flags and then clears them at that clock edge. If an event for a flag happens in the same cycle as the read, that flag is left set.
- R7: `irq` is 1 exactly when some flag bit n and mask bit n at address 3 are both 1.
- R8: Addresses 5 to 7 and all unused bits read 0. Writes to addresses 0, 1 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| osc_tick | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; rdata is valid combinationally while it is high |
| bus_rdata | output | 4 | Read data |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The bench drives the count across the 1024, 4096 and 16384 tick boundaries. If a design took the wrong tap or detected the rising edge, the wrong flag bits would be set at those counts. The bench also issues a flag read in the same cycle as a 32 Hz fall. A design that let the clear win there would lose that event, and the next read would return 0.

The bench stops the timer just before a fall is due. A design whose divider leaked ticks while stopped would show a changed tap level or a new flag. It also checks masked flags against `irq`, which catches a request that ignores the mask. Finally, it writes to the read-only addresses, which catches an address decode that lets those writes through.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 4;

  localparam logic [ADDR_W-1:0] A_TAP_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_TAP_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG   = 3'd4;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/tt_divider.sv
module tt_divider #(
  parameter int CNT_W = 15,
  parameter int TAP_N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic [TAP_N-1:0] taps,
  output logic [TAP_N-1:0] falls,
  output logic             step
);
  localparam int TAP_LO = CNT_W - TAP_N;

  function automatic logic [TAP_N-1:0] tap_slice(input logic [CNT_W-1:0] c);
    return c[CNT_W-1:TAP_LO];
  endfunction

  function automatic logic [TAP_N-1:0] fall_bits(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] nxt);
    return tap_slice(cur) & ~tap_slice(nxt);
  endfunction

  logic [CNT_W-1:0] cnt_nxt;

  assign step    = tick & run & ~clr;
  assign cnt_nxt = cnt + 1'b1;
  assign taps    = tap_slice(cnt);
  assign falls   = step ? fall_bits(cnt, cnt_nxt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (step)   cnt <= cnt_nxt;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R4
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt)); // R3
  AST_STOP_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (falls == '0)); // R3
endmodule

// File: rtl/tt_irq_unit.sv
module tt_irq_unit #(
  parameter int SRC_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] ev,
  input  logic [SRC_N-1:0] mask,
  input  logic             rd_clr,
  output logic [SRC_N-1:0] flags,
  output logic             irq
);
  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (ev[i])  flags[i] <= 1'b1;
      else if (rd_clr) flags[i] <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> flags[i]); // R6
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !ev[i]) |=> !flags[i]); // R6
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_clr && !ev[i]) |=> $stable(flags[i])); // R5
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/tt_regfile.sv
module tt_regfile
  import tt_pkg::*;
#(
  parameter int TAP_N = 8,
  parameter int SRC_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic [TAP_N-1:0]  taps,
  input  logic [SRC_N-1:0]  flags,
  output logic              run,
  output logic              clr,
  output logic [SRC_N-1:0]  mask,
  output logic              rd_flag,
  output logic [DATA_W-1:0] rdata
);
  logic wr_ctrl, wr_mask;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_mask = wr && (addr == A_MASK);
  assign clr     = wr_ctrl && wdata[CTRL_CLR_BIT];
  assign rd_flag = rd && (addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      mask <= '0;
    end else begin
      if (wr_ctrl) run  <= wdata[CTRL_RUN_BIT];
      if (wr_mask) mask <= wdata[SRC_N-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_TAP_LO: rdata = taps[DATA_W-1:0];
      A_TAP_HI: rdata = taps[2*DATA_W-1:DATA_W];
      A_CTRL:   rdata[CTRL_RUN_BIT] = run;
      A_MASK:   rdata[SRC_N-1:0] = mask;
      A_FLAG:   rdata[SRC_N-1:0] = flags;
      default:  rdata = '0;
    endcase
  end

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > A_FLAG) |-> (rdata == '0)); // R8
  AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (run == $past(wdata[CTRL_RUN_BIT]))); // R3
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask)); // R8
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int CNT_W      = 15,
  parameter int TAP_N      = 8,
  parameter int SRC_N      = 3,
  parameter int SRC_TAP0   = 2,
  parameter int SRC_STRIDE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_tick,
  input  logic [2:0]  bus_addr,
  input  logic [3:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [3:0]  bus_rdata,
  output logic        irq
);
  logic [CNT_W-1:0] cnt;
  logic [TAP_N-1:0] taps, falls;
  logic [SRC_N-1:0] ev, mask, flags;
  logic             step, run, clr, rd_flag;

  tt_divider #(.CNT_W(CNT_W), .TAP_N(TAP_N)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .run(run), .clr(clr),
    .cnt(cnt), .taps(taps), .falls(falls), .step(step)
  );

  for (genvar i = 0; i < SRC_N; i++) begin : g_ev
    assign ev[i] = falls[SRC_TAP0 + SRC_STRIDE*i];
  end

  tt_irq_unit #(.SRC_N(SRC_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev), .mask(mask), .rd_clr(rd_flag),
    .flags(flags), .irq(irq)
  );

  tt_regfile #(.TAP_N(TAP_N), .SRC_N(SRC_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .wr(bus_wr), .rd(bus_rd), .taps(taps), .flags(flags),
    .run(run), .clr(clr), .mask(mask), .rd_flag(rd_flag), .rdata(bus_rdata)
  );

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R7
  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (osc_tick && run)); // R2
endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  logic [3:0] v;

  always #4 clk = ~clk;

  tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int lo_of(input int c);
    return (c / 128) % 16;
  endfunction
  function automatic int hi_of(input int c);
    return (c / 2048) % 16;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n, input bit running);
    @(negedge clk); osc_tick = 1'b1;
    repeat (n) @(negedge clk);
    osc_tick = 1'b0;
    if (running) exp_cnt += n;
  endtask

  task automatic t_reset;
    rd_reg(3'd2, v); chk("R1 ctrl", v, 0);
    rd_reg(3'd3, v); chk("R1 mask", v, 0);
    rd_reg(3'd4, v); chk("R1 flags", v, 0);
    rd_reg(3'd0, v); chk("R1 taplo", v, 0);
    rd_reg(3'd1, v); chk("R1 taphi", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_stopped_from_reset;
    ticks(100, 0);
    rd_reg(3'd0, v); chk("R3 held taplo", v, 0);
    rd_reg(3'd4, v); chk("R3 no flags", v, 0);
  endtask

  task automatic t_count;
    wr_reg(3'd2, 4'h1);
    rd_reg(3'd2, v); chk("R3 run readback", v, 1);
    ticks(300, 1);
    rd_reg(3'd0, v); chk("R2 taplo 300", v, lo_of(exp_cnt));
    rd_reg(3'd1, v); chk("R2 taphi 300", v, hi_of(exp_cnt));
    ticks(1748, 1);
    rd_reg(3'd0, v); chk("R2 taplo 2048", v, lo_of(exp_cnt));
    rd_reg(3'd1, v); chk("R2 taphi 2048", v, hi_of(exp_cnt));
    chk("R7 masked irq", irq, 0);
    rd_reg(3'd4, v); chk("R5 32Hz flag", v, 1);
    rd_reg(3'd4, v); chk("R6 cleared by read", v, 0);
  endtask

  task automatic t_soft_clear;
    wr_reg(3'd2, 4'h3); exp_cnt = 0;
    rd_reg(3'd0, v); chk("R4 taplo cleared", v, 0);
    rd_reg(3'd1, v); chk("R4 taphi cleared", v, 0);
    rd_reg(3'd2, v); chk("R4 clr reads 0", v, 1);
  endtask

  task automatic t_mask;
    ticks(4096, 1);
    chk("R7 no mask", irq, 0);
    wr_reg(3'd3, 4'h1); #1 chk("R7 mask0", irq, 1);
    wr_reg(3'd3, 4'h2); #1 chk("R7 mask1", irq, 1);
    wr_reg(3'd3, 4'h4); #1 chk("R7 mask2 no flag", irq, 0);
    wr_reg(3'd3, 4'h1);
    rd_reg(3'd4, v); chk("R5 32+8Hz flags", v, 3);
    #1 chk("R7 irq after clear", irq, 0);
    wr_reg(3'd3, 4'h0);
  endtask

  task automatic t_slow_taps;
    ticks(12288, 1);
    rd_reg(3'd1, v); chk("R2 1Hz tap", v, hi_of(exp_cnt));
    rd_reg(3'd4, v); chk("R5 all flags", v, 7);
  endtask

  task automatic t_set_wins;
    wr_reg(3'd2, 4'h3); exp_cnt = 0;
    ticks(1023, 1);
    rd_reg(3'd4, v); chk("R6 none before edge", v, 0);
    @(negedge clk); osc_tick = 1'b1; bus_addr = 3'd4; bus_rd = 1'b1;
    #1 v = bus_rdata; chk("R6 old value seen", v, 0);
    @(negedge clk); osc_tick = 1'b0; bus_rd = 1'b0; exp_cnt += 1;
    rd_reg(3'd4, v); chk("R6 set wins over clear", v, 1);
  endtask

  task automatic t_stop_hold;
    wr_reg(3'd2, 4'h0);
    ticks(2000, 0);
    rd_reg(3'd0, v); chk("R3 stopped taplo", v, lo_of(exp_cnt));
    rd_reg(3'd4, v); chk("R3 stopped no flags", v, 0);
  endtask

  task automatic t_unused;
    wr_reg(3'd0, 4'hF);
    rd_reg(3'd0, v); chk("R8 taplo write ignored", v, lo_of(exp_cnt));
    wr_reg(3'd1, 4'hF);
    rd_reg(3'd1, v); chk("R8 taphi write ignored", v, hi_of(exp_cnt));
    wr_reg(3'd4, 4'hF);
    rd_reg(3'd4, v); chk("R8 flag write ignored", v, 0);
    for (int a = 5; a < 8; a++) begin
      rd_reg(3'(a), v); chk("R8 unused address", v, 0);
    end
    wr_reg(3'd3, 4'hF);
    rd_reg(3'd3, v); chk("R8 mask bit3 zero", v, 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stopped_from_reset();
    t_count();
    t_soft_clear();
    t_mask();
    t_slow_taps();
    t_set_wins();
    t_stop_hold();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule